// File: doc/BRIEF.md
# Dual-Pipe Ordered Store Buffer

This block sits between two parallel issue pipes and a single memory bus. Each pipe can post a write in any clock, and both may post in the same clock. Posted writes are held in a small buffer per pipe, so the pipes can continue while the bus is busy. They are sent to the bus one per handshake, in exactly the order in which they were generated, whichever pipe they came from.

A read request never overtakes buffered writes. It reaches the bus only when no write is pending in either buffer. The block raises a single stall output whenever it cannot take everything presented in the current clock. This happens when a write targets a full buffer or when a read cannot be issued yet. In a stalled clock nothing is taken, and the pipes hold their requests and present them again.

Top module: `dual_wbuf`

## Requirements
- R1: After reset both buffers are empty: with no request presented, `bus_valid` and `stall` are 0.
- R2: A write taken in a clock (`stall`=0) appears on the bus with `bus_write`=1 in the following clock at the earliest, with its own address and data.
- R3: When both pipes post a write in the same clock, the pipe A write drains first if `pair_b_older`=0, and the pipe B write drains first if `pair_b_older`=1.
- R4: Across both pipes, writes drain to the bus in the order in which they were taken.
- R5: While `bus_valid`=1 with `bus_write`=1 and `bus_ready`=0, the next clock shows the same write (address, data, `bus_write`) on the bus.
- R6: Each pipe buffer holds `DEPTH` writes. A write to a full buffer whose head is not draining this clock raises `stall`, and in a stalled clock no write from either pipe is taken.
- R7: A write to a full buffer is taken without stall in the clock in which that same buffer's head is accepted by the bus.
- R8: A read is driven on the bus (`bus_valid`=1, `bus_write`=0, `bus_addr`=`rd_addr`) only when no write is pending, and `stall` stays 1 while a presented read has not been accepted.
- R9: A read presented with both buffers empty is on the bus in the same clock, and `stall` is 0 in the clock where `bus_ready`=1.
- R10: Writes presented together with a read are taken only in the clock the read is accepted, and they drain after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr_valid | input | 1 | Pipe A write request |
| a_wr_addr | input | AW | Pipe A write address |
| a_wr_data | input | DW | Pipe A write data |
| b_wr_valid | input | 1 | Pipe B write request |
| b_wr_addr | input | AW | Pipe B write address |
| b_wr_data | input | DW | Pipe B write data |
| pair_b_older | input | 1 | Same-clock pair: 1 makes pipe B's write the older one |
| rd_valid | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| stall | output | 1 | Nothing presented this clock is taken |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data (0 for reads) |
| bus_ready | input | 1 | Bus accepts the current request |

## Verification
The bus outputs and `stall` are combinational from the registered buffer state. A write taken at a rising edge can therefore first be seen on the bus in the clock after that edge. A read with empty buffers, and the stall decision, are seen in the clock in which they are presented. The bench applies inputs at the falling edge and compares every output 2 ns later against a behavioural queue model. It advances the model only at the following rising edge, so each expected value is due in exactly the cycle in which it is checked.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
    localparam int NUM_PIPES = 2;

    typedef enum logic {
        PIPE_A = 1'b0,
        PIPE_B = 1'b1
    } pipe_id_e;
endpackage

// File: rtl/wb_slot_fifo.sv
module wb_slot_fifo #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [AW-1:0] head_addr_o,
    output logic [DW-1:0] head_data_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic  [CW-1:0]    cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        logic [CW-1:0] cnt_v;
        st_d  = st_q;
        cnt_v = st_q.cnt;
        if (pop_i && cnt_v != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.slot[DEPTH-1] = '0;
            cnt_v = cnt_v - 1'b1;
        end
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(cnt_v)) begin
                    st_d.slot[i].addr = push_addr_i;
                    st_d.slot[i].data = push_data_i;
                end
            end
            cnt_v = cnt_v + 1'b1;
        end
        st_d.cnt = cnt_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_addr_o = st_q.slot[0].addr;
    assign head_data_o = st_q.slot[0].data;
    assign count_o     = st_q.cnt;
endmodule

// File: rtl/wb_order_queue.sv
module wb_order_queue #(
    parameter int QDEPTH = 4,
    localparam int QCW   = $clog2(QDEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     push_n_i,
    input  logic [1:0]     push_ids_i,
    input  logic           pop_i,
    output logic           head_id_o,
    output logic           empty_o
);
    typedef struct packed {
        logic [QDEPTH-1:0] ids;
        logic [QCW-1:0]    cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        logic [QCW-1:0] cnt_v;
        st_d  = st_q;
        cnt_v = st_q.cnt;
        if (pop_i && cnt_v != '0) begin
            st_d.ids = st_q.ids >> 1;
            cnt_v    = cnt_v - 1'b1;
        end
        for (int k = 0; k < 2; k++) begin
            if (int'(push_n_i) > k) begin
                for (int i = 0; i < QDEPTH; i++) begin
                    if (i == int'(cnt_v)) st_d.ids[i] = push_ids_i[k];
                end
                cnt_v = cnt_v + 1'b1;
            end
        end
        st_d.cnt = cnt_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_id_o = st_q.ids[0];
    assign empty_o   = (st_q.cnt == '0);
endmodule

// File: rtl/dual_wbuf.sv
module dual_wbuf #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wr_valid,
    input  logic [AW-1:0] a_wr_addr,
    input  logic [DW-1:0] a_wr_data,
    input  logic          b_wr_valid,
    input  logic [AW-1:0] b_wr_addr,
    input  logic [DW-1:0] b_wr_data,
    input  logic          pair_b_older,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          stall,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready
);
    import dwb_pkg::*;

    localparam int NP = NUM_PIPES;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int QD = NP * DEPTH;

    logic [NP-1:0] in_v, room, push, drain_p;
    logic [AW-1:0] in_addr [NP];
    logic [DW-1:0] in_data [NP];
    logic [AW-1:0] h_addr  [NP];
    logic [DW-1:0] h_data  [NP];
    logic [CW-1:0] cnt     [NP];

    logic     oq_empty, pending, drain, rd_block, take;
    logic     head_raw;
    pipe_id_e head;
    logic [1:0] oq_push_n, oq_push_ids;

    logic [CW-1:0] occ_a, occ_b;
    logic          drain_a, drain_b;

    assign in_v    = {b_wr_valid, a_wr_valid};
    assign in_addr[PIPE_A] = a_wr_addr;
    assign in_addr[PIPE_B] = b_wr_addr;
    assign in_data[PIPE_A] = a_wr_data;
    assign in_data[PIPE_B] = b_wr_data;

    assign pending = !oq_empty;
    assign head    = pipe_id_e'(head_raw);
    assign drain   = pending && bus_ready;

    for (genvar p = 0; p < NP; p++) begin : g_pipe
        assign drain_p[p] = drain && (head == pipe_id_e'(p));
        assign room[p]    = (cnt[p] < CW'(DEPTH)) || drain_p[p];
        assign push[p]    = take && in_v[p];

        wb_slot_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (push[p]),
            .push_addr_i (in_addr[p]),
            .push_data_i (in_data[p]),
            .pop_i       (drain_p[p]),
            .head_addr_o (h_addr[p]),
            .head_data_o (h_data[p]),
            .count_o     (cnt[p])
        );
    end

    // read waits for an empty buffer pair and a bus handshake
    assign rd_block = rd_valid && !(!pending && bus_ready);
    assign stall    = rd_block || |(in_v & ~room);
    assign take     = !stall;

    always_comb begin
        oq_push_n   = 2'd0;
        oq_push_ids = 2'b00;
        if (take) begin
            if (in_v[PIPE_A] && in_v[PIPE_B]) begin
                oq_push_n   = 2'd2;
                oq_push_ids = pair_b_older ? {PIPE_A, PIPE_B} : {PIPE_B, PIPE_A};
            end else if (in_v[PIPE_A]) begin
                oq_push_n   = 2'd1;
                oq_push_ids = {1'b0, PIPE_A};
            end else if (in_v[PIPE_B]) begin
                oq_push_n   = 2'd1;
                oq_push_ids = {1'b0, PIPE_B};
            end
        end
    end

    wb_order_queue #(.QDEPTH(QD)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_n_i   (oq_push_n),
        .push_ids_i (oq_push_ids),
        .pop_i      (drain),
        .head_id_o  (head_raw),
        .empty_o    (oq_empty)
    );

    always_comb begin
        bus_valid = pending || rd_valid;
        bus_write = pending;
        bus_addr  = pending ? h_addr[head] : rd_addr;
        bus_wdata = pending ? h_data[head] : '0;
    end

    assign occ_a   = cnt[PIPE_A];
    assign occ_b   = cnt[PIPE_B];
    assign drain_a = drain_p[PIPE_A];
    assign drain_b = drain_p[PIPE_B];
endmodule

// File: rtl/dwb_checker.sv
module dwb_checker #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_wr_valid,
    input logic          b_wr_valid,
    input logic          rd_valid,
    input logic          stall,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ready,
    input logic [CW-1:0] occ_a,
    input logic [CW-1:0] occ_b,
    input logic          drain_a,
    input logic          drain_b
);
    a_r2_posted_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (a_wr_valid || b_wr_valid)) |=> (bus_valid && bus_write));

    a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_ready) |=>
        (bus_valid && bus_write && $stable(bus_addr) && $stable(bus_wdata)));

    a_r6_full_a_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_valid && occ_a == CW'(DEPTH) && !drain_a) |-> stall);

    a_r6_full_b_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr_valid && occ_b == CW'(DEPTH) && !drain_b) |-> stall);

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_a <= CW'(DEPTH)) && (occ_b <= CW'(DEPTH)));

    a_r8_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |-> (occ_a == '0 && occ_b == '0));

    a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && bus_valid && !bus_write && bus_ready) |-> !stall);
endmodule

bind dual_wbuf dwb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dwb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_wr_valid (a_wr_valid),
    .b_wr_valid (b_wr_valid),
    .rd_valid   (rd_valid),
    .stall      (stall),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .occ_a      (occ_a),
    .occ_b      (occ_b),
    .drain_a    (drain_a),
    .drain_b    (drain_b)
);

// File: tb/test_dual_wbuf.sv
module test_dual_wbuf;
    localparam int AW = 16, DW = 32, DEPTH = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic av, bv, b_old, rv, rdy;
    logic [AW-1:0] aa, ba, ra;
    logic [DW-1:0] ad, bd;
    logic stall, bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    dual_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_dual_wbuf (
        .clk(clk), .rst_n(rst_n),
        .a_wr_valid(av), .a_wr_addr(aa), .a_wr_data(ad),
        .b_wr_valid(bv), .b_wr_addr(ba), .b_wr_data(bd),
        .pair_b_older(b_old), .rd_valid(rv), .rd_addr(ra),
        .stall(stall), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready_w)
    );
    logic bus_ready_w;
    assign bus_ready_w = rdy;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int p;
    } wr_t;

    wr_t pend[$];
    int  cnt_m [2];
    int  checks = 0, errors = 0;
    logic last_stall;
    bit  done = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        av = 0; bv = 0; rv = 0; b_old = 0;
        aa = '0; ba = '0; ra = '0; ad = '0; bd = '0;
    endtask

    // called at a falling edge with inputs already applied
    task automatic step(string tag);
        logic ev, ew, drain, rd_ok, es;
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        int dp;
        bit ok0, ok1;
        wr_t wa, wb;
        #2;
        ew = (pend.size() > 0);
        ev = ew || rv;
        ea = ew ? pend[0].a : ra;
        ed = ew ? pend[0].d : '0;
        chk(tag, "bus_valid", 64'(bus_valid), 64'(ev));
        if (ev) begin
            chk(tag, "bus_write", 64'(bus_write), 64'(ew));
            chk(tag, "bus_addr", 64'(bus_addr), 64'(ea));
        end
        if (ew) chk(tag, "bus_wdata", 64'(bus_wdata), 64'(ed));
        drain = ew && rdy;
        dp    = drain ? pend[0].p : -1;
        ok0   = (cnt_m[0] < DEPTH) || (dp == 0);
        ok1   = (cnt_m[1] < DEPTH) || (dp == 1);
        rd_ok = !rv || (!ew && rdy);
        es    = (av && !ok0) || (bv && !ok1) || !rd_ok;
        chk(tag, "stall", 64'(stall), 64'(es));
        last_stall = es;
        @(posedge clk);
        if (drain) begin
            cnt_m[pend[0].p]--;
            void'(pend.pop_front());
        end
        if (!es) begin
            wa.a = aa; wa.d = ad; wa.p = 0;
            wb.a = ba; wb.d = bd; wb.p = 1;
            if (av && bv && b_old) begin
                pend.push_back(wb); pend.push_back(wa);
            end else begin
                if (av) pend.push_back(wa);
                if (bv) pend.push_back(wb);
            end
            if (av) cnt_m[0]++;
            if (bv) cnt_m[1]++;
        end
        @(negedge clk);
    endtask

    task automatic wa_set(logic [AW-1:0] a, logic [DW-1:0] d);
        av = 1; aa = a; ad = d;
    endtask
    task automatic wb_set(logic [AW-1:0] a, logic [DW-1:0] d);
        bv = 1; ba = a; bd = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cnt_m[0] = 0; cnt_m[1] = 0;
        idle(); rdy = 0; rst_n = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: empty after reset
        step("R1"); step("R1");

        // R2: single posted writes reach the bus next cycle
        rdy = 1;
        wa_set(16'h0010, 32'hA0000001); step("R2");
        idle(); wb_set(16'h0020, 32'hB0000001); step("R2");
        idle(); step("R2"); step("R2");

        // R3: same-clock pair, default and swapped age
        rdy = 0;
        wa_set(16'h0100, 32'hA1); wb_set(16'h0200, 32'hB1); step("R3");
        idle(); b_old = 1; wa_set(16'h0101, 32'hA2); wb_set(16'h0201, 32'hB2); step("R3");
        idle(); rdy = 1;
        repeat (5) step("R3");

        // R5 and R6: hold with ready low, fill pipe A and hit stall
        rdy = 0;
        wa_set(16'h0300, 32'hC0); step("R5");
        wa_set(16'h0301, 32'hC1); step("R5");
        wa_set(16'h0302, 32'hC2); wb_set(16'h0400, 32'hD0); step("R6");
        chk("R6", "stall on full", 64'(last_stall), 64'd1);
        idle(); step("R5");
        // R7: full pipe A head drains while a new A write arrives
        rdy = 1; wa_set(16'h0303, 32'hC3); step("R7");
        chk("R7", "no stall on freeing drain", 64'(last_stall), 64'd0);
        idle(); repeat (4) step("R7");

        // R8: read behind pending writes
        rdy = 1;
        wa_set(16'h0500, 32'hE0); wb_set(16'h0600, 32'hF0); step("R8");
        idle(); rv = 1; ra = 16'h0777;
        for (int n = 0; n < 10; n++) begin
            step("R8");
            if (!last_stall) break;
        end
        chk("R8", "read finally taken", 64'(last_stall), 64'd0);
        idle();

        // R9: read with empty buffers, bus not ready then ready
        rdy = 0; rv = 1; ra = 16'h0888; step("R9");
        chk("R9", "read waits for ready", 64'(last_stall), 64'd1);
        rdy = 1; step("R9");
        chk("R9", "read taken", 64'(last_stall), 64'd0);
        idle();

        // R10: read together with writes
        rdy = 0; rv = 1; ra = 16'h0999; wa_set(16'h0A00, 32'h11); wb_set(16'h0B00, 32'h22);
        step("R10"); step("R10");
        rdy = 1; step("R10");
        idle(); repeat (4) step("R10");

        // R4: mixed traffic
        for (int n = 0; n < 600; n++) begin
            idle();
            av = ($urandom_range(0, 2) != 0); aa = AW'($urandom); ad = $urandom;
            bv = ($urandom_range(0, 2) != 0); ba = AW'($urandom); bd = $urandom;
            b_old = $urandom_range(0, 1) == 1;
            rv = ($urandom_range(0, 9) == 0); ra = AW'($urandom);
            rdy = ($urandom_range(0, 3) != 0);
            step("R4");
        end
        idle(); rdy = 1;
        repeat (8) step("R4");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule